// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small, fully associative set of page-to-frame translations for a memory management unit. Each slot stores an address space identifier, a virtual page number, a frame number, a read-only flag and a present flag. A lookup presents the identifier, the page number, the page offset and the access kind. In the same cycle the block reports a hit with the physical address and protection result, or a miss. A miss tells the surrounding page-table walker to fetch the mapping.

The walker hands the fetched mapping back through the refill port. The mapping goes into the slot that already holds that identifier and page, if one exists. Otherwise it goes into the lowest free slot. When no slot is free, it overwrites the slot chosen by a round-robin pointer. The identifier tag lets mappings of several processes live side by side, so a context switch needs no flush. Two flush controls remain for the operating system: one clears everything, the other clears only the slots of one identifier.

Top module: `tlb_asid`

## Requirements
- R1: With `lk_valid` high, `lk_hit` is high in the same cycle exactly when a valid slot matches both `lk_asid` and `lk_vpn`, and `lk_miss` is high otherwise. With `lk_valid` low, both are low.
- R2: On a hit, `lk_paddr` is the slot's frame number in the upper bits with `lk_offset` unchanged in the low offset bits. On a miss, `lk_paddr` is zero.
- R3: A mapping supplied with `rf_valid` high is written at that clock edge and hits from the next cycle on.
- R4: Mappings that share a page number but carry different identifiers are held and returned independently. A lookup under an identifier with no such mapping misses.
- R5: `lk_ro` shows the read-only flag of the hit slot and is 0 on a miss. A write (`lk_write`=1) that hits a read-only slot raises `lk_fault`. A read of that slot does not, and `lk_hit` stays high.
- R6: A hit on a slot installed with `rf_present`=0 raises `lk_fault` for both reads and writes.
- R7: A refill whose identifier and page already sit in a valid slot replaces that slot's contents and uses no further slot.
- R8: A refill with no matching slot takes the lowest-numbered invalid slot before any valid slot is overwritten.
- R9: When every slot is valid, a new refill overwrites the slot at a round-robin pointer. The pointer starts at slot 0 after reset and moves up by one, wrapping, on each such overwrite only.
- R10: `fl_all` invalidates every slot at the edge. `fl_asid_en` invalidates only the slots whose identifier equals `fl_asid`, and slots of other identifiers keep hitting.
- R11: A refill in the same cycle as either flush is dropped. The flush alone takes effect, and `fl_all` wins over `fl_asid_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the cache |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Identifier of the requesting address space |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_offset | input | OFF_W | Offset within the page |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, refill needed |
| lk_fault | output | 1 | Protection trap on the hit slot |
| lk_ro | output | 1 | Read-only flag of the hit slot |
| lk_paddr | output | PFN_W+OFF_W | Physical address |
| rf_valid | input | 1 | Install a mapping |
| rf_asid | input | ASID_W | Identifier of the mapping |
| rf_vpn | input | VPN_W | Page number of the mapping |
| rf_pfn | input | PFN_W | Frame number of the mapping |
| rf_ro | input | 1 | Read-only flag of the mapping |
| rf_present | input | 1 | Present flag of the mapping |
| fl_all | input | 1 | Invalidate every slot |
| fl_asid_en | input | 1 | Invalidate the slots of one identifier |
| fl_asid | input | ASID_W | Identifier for the selective flush |

## Verification
The hardest cases to reach from the ports are those that depend on which slot a refill lands in. That placement cannot be seen directly. It shows only later, as which old mapping disappears. The stimulus resets, fills all slots in a known order, then forces overwrites and watches which earlier page starts to miss. This shows both the pointer order and that a repeated refill used no slot. For free-slot reuse, it clears one identifier out of a full cache and refills. Every mapping of the other identifier must survive, which would fail if a valid slot had been overwritten.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Where a refill is placed.
    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_REUSE = 2'd1,
        SLOT_FREE  = 2'd2,
        SLOT_EVICT = 2'd3
    } slot_src_e;

    // Same pair first, then an empty slot, then the round-robin victim.
    function automatic slot_src_e pick_slot(input logic req,
                                            input logic same_found,
                                            input logic free_found);
        if (!req)
            return SLOT_NONE;
        else if (same_found)
            return SLOT_REUSE;
        else if (free_found)
            return SLOT_FREE;
        else
            return SLOT_EVICT;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic [N-1:0]              ent_valid,
    input  logic [N-1:0][VPN_W-1:0]   ent_vpn,
    input  logic [N-1:0][ASID_W-1:0]  ent_asid,
    input  logic [VPN_W-1:0]          key_vpn,
    input  logic [ASID_W-1:0]         key_asid,
    output logic [N-1:0]              match
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent_valid[i] &&
                          (ent_vpn[i]  == key_vpn) &&
                          (ent_asid[i] == key_asid);
    end

endmodule

// File: rtl/tlb_prienc.sv
module tlb_prienc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm (
    input  logic hit,
    input  logic present,
    input  logic ro,
    input  logic write,
    output logic fault,
    output logic ro_out
);

    always_comb begin
        fault  = hit && (!present || (write && ro));
        ro_out = hit && ro;
    end

endmodule

// File: rtl/tlb_asid.sv
module tlb_asid #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8,
    parameter int OFF_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic [VPN_W-1:0]        lk_vpn,
    input  logic [OFF_W-1:0]        lk_offset,
    input  logic                    lk_write,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic                    lk_fault,
    output logic                    lk_ro,
    output logic [PFN_W+OFF_W-1:0]  lk_paddr,
    input  logic                    rf_valid,
    input  logic [ASID_W-1:0]       rf_asid,
    input  logic [VPN_W-1:0]        rf_vpn,
    input  logic [PFN_W-1:0]        rf_pfn,
    input  logic                    rf_ro,
    input  logic                    rf_present,
    input  logic                    fl_all,
    input  logic                    fl_asid_en,
    input  logic [ASID_W-1:0]       fl_asid
);
    import tlb_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]              valid;
        logic [ENTRIES-1:0]              present;
        logic [ENTRIES-1:0]              ro;
        logic [ENTRIES-1:0][ASID_W-1:0]  asid;
        logic [ENTRIES-1:0][VPN_W-1:0]   vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]   pfn;
        logic [IDX_W-1:0]                rr;
    } tlb_state_t;

    tlb_state_t st_q, st_d;

    // Lookup path
    logic [ENTRIES-1:0] lk_match;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_idx;
    logic               hit_int;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .ent_valid (st_q.valid),
        .ent_vpn   (st_q.vpn),
        .ent_asid  (st_q.asid),
        .key_vpn   (lk_vpn),
        .key_asid  (lk_asid),
        .match     (lk_match)
    );

    tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
        .req   (lk_match),
        .found (lk_found),
        .idx   (lk_idx)
    );

    assign hit_int  = lk_valid && lk_found;
    assign lk_hit   = hit_int;
    assign lk_miss  = lk_valid && !lk_found;
    assign lk_paddr = hit_int ? {st_q.pfn[lk_idx], lk_offset} : PA_W'(0);

    tlb_perm u_perm (
        .hit     (hit_int),
        .present (st_q.present[lk_idx]),
        .ro      (st_q.ro[lk_idx]),
        .write   (lk_write),
        .fault   (lk_fault),
        .ro_out  (lk_ro)
    );

    // Refill placement
    logic [ENTRIES-1:0] rf_match;
    logic               same_found;
    logic [IDX_W-1:0]   same_idx;
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;
    slot_src_e          slot_src;
    logic [IDX_W-1:0]   slot_idx;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
        .ent_valid (st_q.valid),
        .ent_vpn   (st_q.vpn),
        .ent_asid  (st_q.asid),
        .key_vpn   (rf_vpn),
        .key_asid  (rf_asid),
        .match     (rf_match)
    );

    tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_same_enc (
        .req   (rf_match),
        .found (same_found),
        .idx   (same_idx)
    );

    tlb_prienc #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
        .req   (~st_q.valid),
        .found (free_found),
        .idx   (free_idx)
    );

    always_comb begin
        st_d     = st_q;
        slot_src = pick_slot(rf_valid && !fl_all && !fl_asid_en,
                             same_found, free_found);
        case (slot_src)
            SLOT_REUSE: slot_idx = same_idx;
            SLOT_FREE:  slot_idx = free_idx;
            default:    slot_idx = st_q.rr;
        endcase

        if (fl_all) begin
            st_d.valid = '0;
        end else if (fl_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.asid[i] == fl_asid)
                    st_d.valid[i] = 1'b0;
            end
        end else if (slot_src != SLOT_NONE) begin
            st_d.valid[slot_idx]   = 1'b1;
            st_d.present[slot_idx] = rf_present;
            st_d.ro[slot_idx]      = rf_ro;
            st_d.asid[slot_idx]    = rf_asid;
            st_d.vpn[slot_idx]     = rf_vpn;
            st_d.pfn[slot_idx]     = rf_pfn;
            if (slot_src == SLOT_EVICT)
                st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 16,
    parameter int ASID_W = 8,
    parameter int OFF_W  = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [ASID_W-1:0]      lk_asid,
    input logic [VPN_W-1:0]       lk_vpn,
    input logic [OFF_W-1:0]       lk_offset,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic                   lk_fault,
    input logic                   lk_ro,
    input logic [PFN_W+OFF_W-1:0] lk_paddr,
    input logic                   rf_valid,
    input logic [ASID_W-1:0]      rf_asid,
    input logic [VPN_W-1:0]       rf_vpn,
    input logic [PFN_W-1:0]       rf_pfn,
    input logic                   fl_all,
    input logic                   fl_asid_en,
    input logic [ASID_W-1:0]      fl_asid
);

    assert_hit_miss_split_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_offset));

    assert_refill_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rf_valid) && !$past(fl_all) && !$past(fl_asid_en) && lk_valid &&
         lk_asid == $past(rf_asid) && lk_vpn == $past(rf_vpn))
        |-> (lk_hit && lk_paddr[PFN_W+OFF_W-1:OFF_W] == $past(rf_pfn)));

    assert_fault_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault || lk_ro) |-> lk_hit);

    assert_flush_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fl_all) |-> !lk_hit);

    assert_flush_asid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_asid_en) && lk_asid == $past(fl_asid)) |-> !lk_hit);

endmodule

bind tlb_asid tlb_asid_chk #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .OFF_W(OFF_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_asid(lk_asid),
    .lk_vpn(lk_vpn), .lk_offset(lk_offset), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_ro(lk_ro), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
    .fl_all(fl_all), .fl_asid_en(fl_asid_en), .fl_asid(fl_asid)
);

// File: tb/tlb_asid_tb_top.sv
module tlb_asid_tb_top;
    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 16;
    localparam int ASID_W  = 8;
    localparam int OFF_W   = 12;
    localparam int PA_W    = PFN_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [OFF_W-1:0]  lk_offset = '0;
    logic              lk_write = 1'b0;
    logic              lk_hit, lk_miss, lk_fault, lk_ro;
    logic [PA_W-1:0]   lk_paddr;
    logic              rf_valid = 1'b0;
    logic [ASID_W-1:0] rf_asid = '0;
    logic [VPN_W-1:0]  rf_vpn = '0;
    logic [PFN_W-1:0]  rf_pfn = '0;
    logic              rf_ro = 1'b0;
    logic              rf_present = 1'b0;
    logic              fl_all = 1'b0;
    logic              fl_asid_en = 1'b0;
    logic [ASID_W-1:0] fl_asid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tlb_asid #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
               .ASID_W(ASID_W), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_asid(lk_asid),
        .lk_vpn(lk_vpn), .lk_offset(lk_offset), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_ro(lk_ro),
        .lk_paddr(lk_paddr), .rf_valid(rf_valid), .rf_asid(rf_asid),
        .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_ro(rf_ro), .rf_present(rf_present),
        .fl_all(fl_all), .fl_asid_en(fl_asid_en), .fl_asid(fl_asid)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic refill(input int a, input int v, input int p,
                          input bit ro, input bit pres);
        @(negedge clk);
        rf_valid = 1'b1; rf_asid = ASID_W'(a); rf_vpn = VPN_W'(v);
        rf_pfn = PFN_W'(p); rf_ro = ro; rf_present = pres;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic flush(input bit all, input bit sel, input int a,
                         input bit with_refill, input int ra, input int rv);
        @(negedge clk);
        fl_all = all; fl_asid_en = sel; fl_asid = ASID_W'(a);
        rf_valid = with_refill; rf_asid = ASID_W'(ra); rf_vpn = VPN_W'(rv);
        rf_pfn = 16'h0bad; rf_ro = 1'b0; rf_present = 1'b1;
        @(negedge clk);
        fl_all = 1'b0; fl_asid_en = 1'b0; rf_valid = 1'b0;
    endtask

    // One lookup, checked against the expected port values.
    task automatic look(input string req, input int a, input int v, input int off,
                        input bit wr, input bit e_hit, input int e_pfn,
                        input bit e_fault, input bit e_ro);
        logic [PA_W-1:0] e_pa;
        @(negedge clk);
        lk_valid = 1'b1; lk_asid = ASID_W'(a); lk_vpn = VPN_W'(v);
        lk_offset = OFF_W'(off); lk_write = wr;
        #2;
        e_pa = e_hit ? {PFN_W'(e_pfn), OFF_W'(off)} : '0;
        checks++;
        if (lk_hit !== e_hit || lk_miss !== !e_hit || lk_paddr !== e_pa ||
            lk_fault !== e_fault || lk_ro !== e_ro) begin
            errors++;
            $display("FAIL %s a=%0d v=%0d: got hit=%b miss=%b pa=%h fault=%b ro=%b exp hit=%b pa=%h fault=%b ro=%b",
                     req, a, v, lk_hit, lk_miss, lk_paddr, lk_fault, lk_ro,
                     e_hit, e_pa, e_fault, e_ro);
        end
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        look("R1", 1, 5, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        lk_asid = 8'd1; lk_vpn = 20'd5;
        #2;
        checks++;
        if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle: got hit=%b miss=%b exp 0 0", lk_hit, lk_miss);
        end
    endtask

    task automatic t_basic();
        refill(1, 5, 'h1234, 0, 1);
        look("R3", 1, 5, 'h0ab, 0, 1, 'h1234, 0, 0);
        look("R2", 1, 5, 'hfff, 1, 1, 'h1234, 0, 0);
        look("R2", 1, 6, 'h010, 0, 0, 0, 0, 0);
    endtask

    task automatic t_asid();
        refill(2, 5, 'h2222, 0, 1);
        look("R4", 1, 5, 'h001, 0, 1, 'h1234, 0, 0);
        look("R4", 2, 5, 'h002, 0, 1, 'h2222, 0, 0);
        look("R4", 3, 5, 'h003, 0, 0, 0, 0, 0);
    endtask

    task automatic t_protect();
        refill(1, 7, 'h0aaa, 1, 1);
        look("R5", 1, 7, 'h004, 0, 1, 'h0aaa, 0, 1);
        look("R5", 1, 7, 'h004, 1, 1, 'h0aaa, 1, 1);
        refill(1, 8, 'h0bbb, 0, 0);
        look("R6", 1, 8, 'h005, 0, 1, 'h0bbb, 1, 0);
        look("R6", 1, 8, 'h005, 1, 1, 'h0bbb, 1, 0);
    endtask

    task automatic t_dup_and_evict();
        do_reset();
        for (int i = 0; i < ENTRIES; i++) refill(3, i, 'h100 + i, 0, 1);
        refill(3, 3, 'h555, 0, 1);
        for (int i = 0; i < ENTRIES; i++)
            look("R7", 3, i, 'h00c, 0, 1, (i == 3) ? 'h555 : 'h100 + i, 0, 0);
        refill(3, 20, 'h800, 0, 1);
        look("R9", 3, 0, 0, 0, 0, 0, 0, 0);
        look("R9", 3, 20, 0, 0, 1, 'h800, 0, 0);
        look("R9", 3, 1, 0, 0, 1, 'h101, 0, 0);
        refill(3, 21, 'h801, 0, 1);
        look("R9", 3, 1, 0, 0, 0, 0, 0, 0);
        look("R9", 3, 2, 0, 0, 1, 'h102, 0, 0);
    endtask

    task automatic t_free_reuse();
        do_reset();
        for (int i = 0; i < 4; i++) refill(5, i, 'h500 + i, 0, 1);
        for (int i = 0; i < 4; i++) refill(6, i, 'h600 + i, 0, 1);
        flush(0, 1, 5, 0, 0, 0);
        look("R10", 5, 0, 0, 0, 0, 0, 0, 0);
        look("R10", 6, 0, 0, 0, 1, 'h600, 0, 0);
        for (int i = 0; i < 4; i++) refill(7, i, 'h700 + i, 0, 1);
        for (int i = 0; i < 4; i++) begin
            look("R8", 6, i, 'h011, 0, 1, 'h600 + i, 0, 0);
            look("R8", 7, i, 'h022, 0, 1, 'h700 + i, 0, 0);
        end
    endtask

    task automatic t_flush();
        flush(1, 0, 0, 0, 0, 0);
        look("R10", 6, 1, 0, 0, 0, 0, 0, 0);
        look("R10", 7, 1, 0, 0, 0, 0, 0, 0);
        flush(1, 0, 0, 1, 8, 1);
        look("R11", 8, 1, 0, 0, 0, 0, 0, 0);
        flush(0, 1, 9, 1, 8, 2);
        look("R11", 8, 2, 0, 0, 0, 0, 0, 0);
        refill(8, 2, 'h333, 0, 1);
        look("R11", 8, 2, 'h00f, 0, 1, 'h333, 0, 0);
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_asid();
        t_protect();
        t_dup_and_evict();
        t_free_reuse();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule